// File: doc/BRIEF.md
# Dual-Comparator Periodic Trigger Timer

This block generates periodic hardware trigger waveforms for a converter or any other consumer that starts work on a signal edge. A prescaler divides the clock. Each time the prescaler wraps, a 32-bit free-running count advances by one. Every channel has two comparators that watch this single count.

The set comparator raises the channel's event flag. When hardware clearing is enabled for the channel, the clear comparator lowers the flag again. After each match, the comparator's value moves forward by the channel's step. Both edges of the waveform therefore repeat with the period step × (prescale + 1) and need no software action.

The event line is taken ahead of the CPU interrupt gate, so the processor can stay quiet while the trigger keeps running. An edge detector turns each event line into a one-cycle trigger pulse. It reacts to falling edges by default and to rising edges when selected. Registers are written through a simple address/data write port.

Top module: `cmptrig_top`

## Requirements
- R1: After reset all event lines, interrupt outputs and trigger pulses are low, the count is 0 and the prescale value is 0.
- R2: A prescale value N (address 0) advances the count once every N+1 clocks. A value of 0 means a divide by 2^32, so after reset the count stays frozen until a nonzero prescale is written. Writing the prescale value restarts the prescale phase.
- R3: When the count reaches a channel's set value (address 16+4*ch) and the channel's event enable (control register at address 1, bits [3:0]) is 1, the flag rises. The set value then grows by the step (address 18+4*ch), so rising edges repeat every step*(N+1) clocks.
- R4: When hardware clear is enabled (control bits [7:4]) and the count reaches the clear value (address 17+4*ch), the flag falls and the clear value grows by the step. The line stays high for (clear - set)*(N+1) clocks, even when the clear value starts below the set value.
- R5: When set and clear match on the same count value, clear wins and no rising edge appears. Both compare values still advance.
- R6: Hardware clear is enabled per channel. A channel without it stays high after its first set match.
- R7: The event line does not depend on the interrupt enable. With its event enable at 0, a channel's line stays low.
- R8: The interrupt output is the flag gated by the interrupt enable (control bits [11:8]). Writing 1 to bit ch at address 2 clears that flag in software.
- R9: The trigger output pulses for exactly one cycle, in the same cycle the event line changes. Control bits [15:12] select the edge: 0 (the reset value) selects falling, 1 selects rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (5) | Register address |
| wr_data | input | 32 | Register write data |
| evt_line | output | NUM_CH (4) | Per-channel event flag, independent of the interrupt enable |
| cpu_irq | output | NUM_CH (4) | Per-channel flag gated by the interrupt enable |
| adc_trig | output | NUM_CH (4) | One-cycle trigger pulse on the selected edge |

## Verification
Two things can fall in the same count cycle. The set comparator and the clear comparator of one channel can match on the same value, and a matching comparator can also be the target of a register write. The coincident-match case is provoked by loading equal set and clear values. The bench then judges that the line never rises over several periods. It also checks that the set value still advanced: once hardware clear is switched off, a rising edge appears, which could not happen if the set value had stayed behind the count. A clear value placed below the set value exercises the ordering in which clear matches before set, and the measured high time must still follow the requirement.

// File: rtl/cmptrig_pkg.sv
package cmptrig_pkg;
  localparam int CW = 32;

  // prescale terminal count: 0 selects the full 2^CW division
  function automatic logic [CW-1:0] psc_limit(input logic [CW-1:0] val);
    return (val == '0) ? '1 : val;
  endfunction

  // compare advance, modulo 2^CW
  function automatic logic [CW-1:0] cmp_advance(input logic [CW-1:0] val,
                                                 input logic [CW-1:0] step);
    return val + step;
  endfunction

  // a match counts only on the cycle the count moves onto the value
  function automatic logic cmp_hit(input logic tick,
                                   input logic [CW-1:0] nxt,
                                   input logic [CW-1:0] val);
    return tick && (nxt == val);
  endfunction
endpackage

// File: rtl/cmptrig_timebase.sv
module cmptrig_timebase
  import cmptrig_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psc_wr,
  input  logic [CW-1:0] psc_val,
  output logic          tick,
  output logic [CW-1:0] cnt_nxt
);
  logic [CW-1:0] psc_q;
  logic [CW-1:0] phase_q;
  logic [CW-1:0] cnt_q;

  assign tick    = (phase_q == psc_limit(psc_q));
  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q   <= '0;
      phase_q <= '0;
    end else if (psc_wr) begin
      psc_q   <= psc_val;
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;
  end

  // R2: the count moves only on a prescale wrap, and then by one
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/cmptrig_chan.sv
module cmptrig_chan
  import cmptrig_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          wr_set,
  input  logic          wr_clr,
  input  logic          wr_step,
  input  logic [CW-1:0] wr_data,
  input  logic          evt_en,
  input  logic          ac_en,
  input  logic          sw_clr,
  output logic          flag,
  output logic          set_hit,
  output logic          clr_hit
);
  logic [CW-1:0] set_q, clr_q, step_q;
  logic          flag_q;

  assign set_hit = cmp_hit(tick, cnt_nxt, set_q);
  assign clr_hit = ac_en && cmp_hit(tick, cnt_nxt, clr_q);
  assign flag    = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= '0;
      clr_q  <= '0;
      step_q <= '0;
    end else begin
      if (wr_step)      step_q <= wr_data;
      if (wr_set)       set_q  <= wr_data;
      else if (set_hit) set_q  <= cmp_advance(set_q, step_q);
      if (wr_clr)       clr_q  <= wr_data;
      else if (clr_hit) clr_q  <= cmp_advance(clr_q, step_q);
    end
  end

  // clear match outranks set match, set match outranks software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag_q <= 1'b0;
    else if (clr_hit)            flag_q <= 1'b0;
    else if (set_hit && evt_en)  flag_q <= 1'b1;
    else if (sw_clr)             flag_q <= 1'b0;
  end

  a_r3_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && evt_en && !clr_hit) |=> flag_q);
  a_r3_set_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && !wr_set) |=> (set_q == $past(set_q) + $past(step_q)));
  a_r4_clr_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !wr_clr) |=> (clr_q == $past(clr_q) + $past(step_q)));
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !flag_q);
  a_r7_no_rise_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_en |=> !$rose(flag_q));
endmodule

// File: rtl/cmptrig_edge.sv
module cmptrig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic rise_sel,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= evt;
  end

  assign pulse = rise_sel ? (evt && !prev_q) : (!evt && prev_q);

  // R9: a pulse marks a real change of the line since the last cycle
  a_r9_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (evt != prev_q));
endmodule

// File: rtl/cmptrig_top.sv
module cmptrig_top
  import cmptrig_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [NUM_CH-1:0] evt_line,
  output logic [NUM_CH-1:0] cpu_irq,
  output logic [NUM_CH-1:0] adc_trig
);
  localparam int LANE      = 4;
  localparam int A_PSC     = 0;
  localparam int A_CTRL    = 1;
  localparam int A_FCLR    = 2;
  localparam int CH_BASE   = 16;
  localparam int CH_STRIDE = 4;

  logic              tick;
  logic [CW-1:0]     cnt_nxt;
  logic [NUM_CH-1:0] evt_en_q, ac_en_q, irq_en_q, rise_q;
  logic [NUM_CH-1:0] sw_clr, set_hit, clr_hit;
  logic              psc_wr, ctrl_wr;

  assign psc_wr  = wr_en && (int'(wr_addr) == A_PSC);
  assign ctrl_wr = wr_en && (int'(wr_addr) == A_CTRL);
  assign sw_clr  = (wr_en && (int'(wr_addr) == A_FCLR)) ? wr_data[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_en_q <= '0;
      ac_en_q  <= '0;
      irq_en_q <= '0;
      rise_q   <= '0;
    end else if (ctrl_wr) begin
      evt_en_q <= wr_data[0*LANE +: NUM_CH];
      ac_en_q  <= wr_data[1*LANE +: NUM_CH];
      irq_en_q <= wr_data[2*LANE +: NUM_CH];
      rise_q   <= wr_data[3*LANE +: NUM_CH];
    end
  end

  cmptrig_timebase u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .psc_wr  (psc_wr),
    .psc_val (wr_data),
    .tick    (tick),
    .cnt_nxt (cnt_nxt)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int BASE = CH_BASE + ch * CH_STRIDE;
    logic wr_set, wr_clr, wr_step;
    assign wr_set  = wr_en && (int'(wr_addr) == BASE + 0);
    assign wr_clr  = wr_en && (int'(wr_addr) == BASE + 1);
    assign wr_step = wr_en && (int'(wr_addr) == BASE + 2);

    cmptrig_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cnt_nxt (cnt_nxt),
      .wr_set  (wr_set),
      .wr_clr  (wr_clr),
      .wr_step (wr_step),
      .wr_data (wr_data),
      .evt_en  (evt_en_q[ch]),
      .ac_en   (ac_en_q[ch]),
      .sw_clr  (sw_clr[ch]),
      .flag    (evt_line[ch]),
      .set_hit (set_hit[ch]),
      .clr_hit (clr_hit[ch])
    );

    cmptrig_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_line[ch]),
      .rise_sel (rise_q[ch]),
      .pulse    (adc_trig[ch])
    );

    assign cpu_irq[ch] = evt_line[ch] && irq_en_q[ch];

    // R8: an interrupt is never raised without the flag behind it
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq[ch] |-> evt_line[ch]);
    // R7: masking the interrupt leaves a set match visible on the line
    a_r7_line_ignores_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hit[ch] && evt_en_q[ch] && !clr_hit[ch] && !irq_en_q[ch]) |=> evt_line[ch]);
  end
endmodule

// File: tb/cmptrig_top_test.sv
module cmptrig_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [NUM_CH-1:0] evt_line, cpu_irq, adc_trig;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  cmptrig_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .evt_line(evt_line), .cpu_irq(cpu_irq), .adc_trig(adc_trig)
  );

  // prescale, set, clear, step, expected high clocks, expected period clocks
  localparam int VEC [4][6] = '{
    '{1, 5, 8, 10, 6, 20},
    '{2, 4, 10, 12, 18, 36},
    '{3, 2, 3, 5, 4, 20},
    '{1, 10, 4, 8, 4, 16}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int ch, input int s, input int c, input int st);
    wr(16 + 4*ch, 32'(s));
    wr(17 + 4*ch, 32'(c));
    wr(18 + 4*ch, 32'(st));
  endtask

  // count negedges until the line shows the level; report trigger seen there
  task automatic wait_lvl(input int ch, input logic lvl, input int lim,
                          output int n, output bit ok, output logic trg);
    n = 0; ok = 1'b0; trg = 1'b0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      n++;
      if (evt_line[ch] == lvl) begin ok = 1'b1; trg = adc_trig[ch]; break; end
    end
  endtask

  initial begin
    int n, hi, lo;
    bit ok;
    logic trg;
    int irq_seen;

    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(evt_line == 0, "R1 evt_line", int'(evt_line), 0);
    chk(cpu_irq == 0 && adc_trig == 0, "R1 irq/trig", int'({cpu_irq, adc_trig}), 0);
    do_reset();

    // R2: prescale 0 keeps the count frozen
    cfg(0, 1, 0, 1);
    wr(1, 32'h0001);
    wait_lvl(0, 1'b1, 100, n, ok, trg);
    chk(!ok, "R2 frozen with prescale 0", int'(ok), 0);

    // R3 R4 R9: table of waveforms on channel 0 with falling-edge trigger
    for (int v = 0; v < 4; v++) begin
      do_reset();
      cfg(0, VEC[v][1], VEC[v][2], VEC[v][3]);
      wr(1, 32'h0011);
      wr(0, 32'(VEC[v][0]));
      wait_lvl(0, 1'b1, 400, n, ok, trg);
      chk(ok, "R3 first rise", int'(ok), 1);
      wait_lvl(0, 1'b0, 400, hi, ok, trg);
      chk(hi == VEC[v][4], "R4 high time", hi, VEC[v][4]);
      chk(trg == 1'b1, "R9 falling trigger at fall", int'(trg), 1);
      wait_lvl(0, 1'b1, 400, lo, ok, trg);
      chk(hi + lo == VEC[v][5], "R3 period", hi + lo, VEC[v][5]);
      chk(trg == 1'b0, "R9 no trigger on rise by default", int'(trg), 0);
      @(negedge clk);
      chk(adc_trig[0] == 1'b0, "R9 pulse is one cycle", int'(adc_trig[0]), 0);
    end

    // R5: coincident set and clear, clear wins, values still advance
    do_reset();
    cfg(0, 5, 5, 10);
    wr(1, 32'h0011);
    wr(0, 32'd1);
    wait_lvl(0, 1'b1, 60, n, ok, trg);
    chk(!ok, "R5 no rise on coincident match", int'(ok), 0);
    wr(1, 32'h0001);
    wait_lvl(0, 1'b1, 60, n, ok, trg);
    chk(ok, "R5 set value advanced", int'(ok), 1);

    // R6: hardware clear only on channel 0
    do_reset();
    cfg(0, 3, 6, 8);
    cfg(1, 3, 6, 8);
    wr(1, 32'h0013);
    wr(0, 32'd1);
    wait_lvl(0, 1'b1, 100, n, ok, trg);
    wait_lvl(0, 1'b0, 100, n, ok, trg);
    chk(ok, "R6 channel 0 cleared", int'(ok), 1);
    repeat (20) @(negedge clk);
    chk(evt_line[1] == 1'b1, "R6 channel 1 stays high", int'(evt_line[1]), 1);

    // R7: line toggles with interrupt masked; no line when event disabled
    do_reset();
    cfg(0, 3, 6, 8);
    wr(1, 32'h0011);
    wr(0, 32'd1);
    irq_seen = 0;
    wait_lvl(0, 1'b1, 100, n, ok, trg);
    chk(ok, "R7 line rises with irq masked", int'(ok), 1);
    chk(cpu_irq[0] == 1'b0, "R7 irq stays masked", int'(cpu_irq[0]), 0);
    wait_lvl(0, 1'b0, 100, hi, ok, trg);
    chk(hi == 6, "R7 high time with irq masked", hi, 6);
    do_reset();
    cfg(0, 3, 6, 8);
    wr(1, 32'h0010);
    wr(0, 32'd1);
    wait_lvl(0, 1'b1, 60, n, ok, trg);
    chk(!ok, "R7 event disabled keeps line low", int'(ok), 0);

    // R8: interrupt gate and software clear
    do_reset();
    cfg(0, 3, 0, 100);
    wr(1, 32'h0101);
    wr(0, 32'd1);
    wait_lvl(0, 1'b1, 100, n, ok, trg);
    chk(cpu_irq[0] == 1'b1, "R8 irq follows flag", int'(cpu_irq[0]), 1);
    wr(2, 32'h1);
    chk(evt_line[0] == 1'b0, "R8 software clear", int'(evt_line[0]), 0);
    chk(cpu_irq[0] == 1'b0, "R8 irq drops with flag", int'(cpu_irq[0]), 0);

    // R9: rising-edge selection
    do_reset();
    cfg(0, 3, 6, 8);
    wr(1, 32'h1011);
    wr(0, 32'd1);
    wait_lvl(0, 1'b1, 100, n, ok, trg);
    chk(trg == 1'b1, "R9 rising trigger at rise", int'(trg), 1);
    wait_lvl(0, 1'b0, 100, n, ok, trg);
    chk(trg == 1'b0, "R9 no trigger on fall when rising", int'(trg), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule